// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Register Controller

This block sits behind a two-wire serial bus front end and turns the byte stream of a write frame into register updates for a two-channel, 10-bit converter. Each channel has a staging (input) register and an active register that drives the converter. Each channel also has a 2-bit power-down mode. The front end supplies three things:
- a strobe for each received byte;
- a strobe on the falling clock edge of the acknowledge bit that follows it;
- pulses for START and STOP conditions.

A frame normally has two bytes. The first byte carries a 4-bit command in its upper nibble and the top four code bits in its lower nibble. The second byte carries the remaining six code bits in its upper part and two sub-bits in its lowest two positions. Two command forms differ from this:
- A one-byte broadcast command copies every staging register to its active register.
- An extended command routes the following byte to the power-down modes. In that byte, bit 3 selects channel B, bit 2 selects channel A, and bits 1:0 give the mode.

A register write takes effect only when the acknowledge strobe arrives for the byte that completes the operation. A START or STOP that arrives before that strobe discards the partial operation.

Top module: `dual_dac_regs`

## Requirements
- R1: After reset both active codes and both staging registers are 0, and both power-down modes are 2'b11.
- R2: Command 4'b0000 writes the code to staging and active A and copies staging B into active B. Command 4'b0001 does the same with the channels swapped.
- R3: Commands 4'b0100 and 4'b0101 write only staging A or staging B. The active codes do not change.
- R4: Commands 4'b1000 and 4'b1001 first copy both staging registers into the active registers. They then write the code into staging A or staging B.
- R5: Command 4'b1100 writes the same code to all four registers. Command 4'b1101 writes it to both staging registers only.
- R6: Command 4'b1110 is a single byte. At its acknowledge strobe it copies both staging registers to the active registers and ignores bits 3:0. The byte that follows is decoded as a new command.
- R7: A first byte of 8'hF0 arms extended mode. At the next byte's acknowledge strobe, mode bits 1:0 are written to channel B if bit 3 is set and to channel A if bit 2 is set. The modes are 00 powered up, 01 floating, 10 1 kΩ pulldown and 11 100 kΩ pulldown. No mode changes any register content.
- R8: Outputs change only in the cycle after an acknowledge strobe that ends an operation. A START or STOP before that strobe leaves every register unchanged and returns decoding to the command byte.
- R9: Undefined command codes are acknowledged with no effect. This includes 4'b1111 with nonzero low bits. The next byte is decoded as a command.
- R10: The two sub-bits in bits 1:0 of the second byte do not affect the stored code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | START or repeated START seen |
| frame_stop | input | 1 | STOP seen |
| byte_valid | input | 1 | A received byte is on byte_data |
| byte_data | input | 8 | Received byte |
| ack_fall | input | 1 | Falling clock edge of the acknowledge bit |
| dac_a | output | 10 | Active code, channel A |
| dac_b | output | 10 | Active code, channel B |
| pd_a | output | 2 | Power-down mode, channel A |
| pd_b | output | 2 | Power-down mode, channel B |

## Verification
The assertions check the following on every cycle:
- outputs move only right after an acknowledge strobe;
- a START or STOP leaves all outputs still and the decoder back at the command byte;
- a staging-only command holds the active codes;
- the both-channel load leaves the two codes equal;
- a power-down write leaves the codes alone.

Some behaviours show up only in the bench's sweep over every command code with varied codes and sub-bits. These are the exact routing of each command between channels and the content of the staging registers, which the bench exposes through a broadcast update. The same applies to the full grid of select bits and modes, and to the abort cases.

// File: rtl/dual_dac_regs.sv
module dual_dac_regs #(
  parameter int DW = 10,
  parameter logic [1:0] PD_RESET = 2'b11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          frame_stop,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  input  logic          ack_fall,
  output logic [DW-1:0] dac_a,
  output logic [DW-1:0] dac_b,
  output logic [1:0]    pd_a,
  output logic [1:0]    pd_b
);
  localparam int LOW = DW - 4;

  typedef enum logic [1:0] {WAIT_CMD, WAIT_DATA, WAIT_EXT} phase_t;

  phase_t        phase;
  logic          held;
  logic [7:0]    hold_byte;
  logic [3:0]    cmd;
  logic [3:0]    hi;
  logic [DW-1:0] in_a, in_b;

  wire           commit = ack_fall && held;
  wire           abort  = frame_start || frame_stop;
  wire [DW-1:0]  word   = {hi, hold_byte[7:8-LOW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= WAIT_CMD;
      held      <= 1'b0;
      hold_byte <= '0;
      cmd       <= '0;
      hi        <= '0;
      in_a      <= '0;
      in_b      <= '0;
      dac_a     <= '0;
      dac_b     <= '0;
      pd_a      <= PD_RESET;
      pd_b      <= PD_RESET;
    end else if (abort) begin
      phase <= WAIT_CMD;
      held  <= 1'b0;
    end else begin
      if (commit) begin
        held <= 1'b0;
        case (phase)
          WAIT_CMD: begin
            case (hold_byte[7:4])
              4'b1110: begin
                dac_a <= in_a;
                dac_b <= in_b;
              end
              4'b1111: if (hold_byte[3:0] == 4'b0000) phase <= WAIT_EXT;
              4'b0000, 4'b0001, 4'b0100, 4'b0101,
              4'b1000, 4'b1001, 4'b1100, 4'b1101: begin
                cmd   <= hold_byte[7:4];
                hi    <= hold_byte[3:0];
                phase <= WAIT_DATA;
              end
              default: ;
            endcase
          end
          WAIT_DATA: begin
            phase <= WAIT_CMD;
            case (cmd)
              4'b0000: begin in_a <= word; dac_a <= word; dac_b <= in_b; end
              4'b0001: begin in_b <= word; dac_b <= word; dac_a <= in_a; end
              4'b0100: in_a <= word;
              4'b0101: in_b <= word;
              4'b1000: begin dac_a <= in_a; dac_b <= in_b; in_a <= word; end
              4'b1001: begin dac_a <= in_a; dac_b <= in_b; in_b <= word; end
              4'b1100: begin in_a <= word; in_b <= word; dac_a <= word; dac_b <= word; end
              4'b1101: begin in_a <= word; in_b <= word; end
              default: ;
            endcase
          end
          WAIT_EXT: begin
            phase <= WAIT_CMD;
            if (hold_byte[2]) pd_a <= hold_byte[1:0];
            if (hold_byte[3]) pd_b <= hold_byte[1:0];
          end
          default: phase <= WAIT_CMD;
        endcase
      end
      if (byte_valid) begin
        hold_byte <= byte_data;
        held      <= 1'b1;
      end
    end
  end

  assert_quiet_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(dac_a) && $stable(dac_b) && $stable(pd_a) && $stable(pd_b)) |-> $past(ack_fall));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> $stable(dac_a) && $stable(dac_b) && $stable(pd_a) && $stable(pd_b)
              && phase == WAIT_CMD && !held);

  assert_inonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !abort && phase == WAIT_DATA && (cmd == 4'b0100 || cmd == 4'b0101 || cmd == 4'b1101))
    |=> $stable(dac_a) && $stable(dac_b));

  assert_bcast_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !abort && phase == WAIT_DATA && cmd == 4'b1100) |=> dac_a == dac_b);

  assert_ext_keeps_dac_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !abort && phase == WAIT_EXT) |=> $stable(dac_a) && $stable(dac_b));
endmodule

// File: tb/dual_dac_regs_test.sv
`timescale 1ns/1ps
module dual_dac_regs_test;
  logic clk = 0, rst_n = 0;
  logic frame_start = 0, frame_stop = 0, byte_valid = 0, ack_fall = 0;
  logic [7:0] byte_data = 0;
  logic [9:0] dac_a, dac_b;
  logic [1:0] pd_a, pd_b;
  logic [9:0] m_ia = 0, m_ib = 0, m_da = 0, m_db = 0;
  logic [1:0] m_pa = 2'b11, m_pb = 2'b11;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dual_dac_regs uut (.clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_stop(frame_stop),
    .byte_valid(byte_valid), .byte_data(byte_data), .ack_fall(ack_fall),
    .dac_a(dac_a), .dac_b(dac_b), .pd_a(pd_a), .pd_b(pd_b));

  task automatic check_all(input string req);
    checks++;
    if (dac_a !== m_da || dac_b !== m_db || pd_a !== m_pa || pd_b !== m_pb) begin
      errors++;
      $display("FAIL %s: got a=%h b=%h pa=%b pb=%b expected a=%h b=%h pa=%b pb=%b",
               req, dac_a, dac_b, pd_a, pd_b, m_da, m_db, m_pa, m_pb);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk) byte_data = b; byte_valid = 1;
    @(negedge clk) byte_valid = 0;
  endtask

  task automatic ack;
    @(negedge clk) ack_fall = 1;
    @(negedge clk) ack_fall = 0;
  endtask

  task automatic send(input logic [7:0] b);
    put_byte(b);
    ack();
  endtask

  task automatic stop;
    @(negedge clk) frame_stop = 1;
    @(negedge clk) frame_stop = 0;
  endtask

  task automatic frame(input logic [3:0] cmd, input logic [9:0] d, input logic [1:0] s, input string req);
    logic two;
    two = cmd inside {4'b0000, 4'b0001, 4'b0100, 4'b0101, 4'b1000, 4'b1001, 4'b1100, 4'b1101};
    send({cmd, d[9:6]});
    if (two) send({d[5:0], s});
    case (cmd)
      4'b0000: begin m_ia = d; m_da = d; m_db = m_ib; end
      4'b0001: begin m_ib = d; m_db = d; m_da = m_ia; end
      4'b0100: m_ia = d;
      4'b0101: m_ib = d;
      4'b1000: begin m_da = m_ia; m_db = m_ib; m_ia = d; end
      4'b1001: begin m_da = m_ia; m_db = m_ib; m_ib = d; end
      4'b1100: begin m_ia = d; m_ib = d; m_da = d; m_db = d; end
      4'b1101: begin m_ia = d; m_ib = d; end
      4'b1110: begin m_da = m_ia; m_db = m_ib; end
      default: ;
    endcase
    stop();
    check_all(req);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: expected completion, got timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");

    // R2 R3 R4 R5 R6 R9 R10: sweep every command with several codes and sub-bit values
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic [9:0] d;
        d = 10'((c * 67 + k * 311 + 5) & 10'h3FF);
        if (c == 15) d[6] = 1'b1;
        frame(4'(c), d, 2'(k), c < 2 ? "R2" : (c == 4 || c == 5) ? "R3" :
              (c == 8 || c == 9) ? "R4" : (c == 12 || c == 13) ? "R5" :
              (c == 14) ? "R6" : "R9");
        frame(4'b1110, 10'h3C0, 2'b00, "R6 expose staging");
      end
    end

    // R10: same code with different sub-bits gives same result
    frame(4'b1100, 10'h2A5, 2'b11, "R10");
    frame(4'b1100, 10'h2A5, 2'b00, "R10");

    // R6: byte after the broadcast is a fresh command
    send(8'hEF);
    m_da = m_ia; m_db = m_ib;
    frame(4'b0000, 10'h155, 2'b01, "R6 follow-on");

    // R7: every select and mode combination
    for (int sel = 0; sel < 4; sel++) begin
      for (int p = 0; p < 4; p++) begin
        send(8'hF0);
        send({4'b0000, 2'(sel), 2'(p)});
        if (sel[0]) m_pa = 2'(p);
        if (sel[1]) m_pb = 2'(p);
        stop();
        check_all("R7");
      end
    end
    frame(4'b1100, 10'h0F3, 2'b00, "R7 codes written while powered down");

    // R8: STOP between last byte and its acknowledge
    send(8'hC3);
    put_byte(8'hFC);
    stop();
    ack();
    check_all("R8 abort before ack");
    // R8: STOP between bytes, then next byte taken as command
    send(8'h0F);
    @(negedge clk) frame_start = 1;
    @(negedge clk) frame_start = 0;
    send(8'h7F);
    send(8'hFF);
    stop();
    check_all("R8 abort between bytes");
    // R8: outputs hold while byte has no acknowledge yet
    send(8'hC0);
    put_byte(8'h40);
    repeat (3) @(negedge clk);
    check_all("R8 no ack no change");
    ack();
    m_ia = 10'h010; m_ib = 10'h010; m_da = 10'h010; m_db = 10'h010;
    stop();
    check_all("R8 commit at ack");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule